// File: doc/BRIEF.md
# Sample-Rate Timing Pulse Selector

This block produces the timing strobes that pace a set of sample-rate-converter channels. Each channel has an input-side lane and an output-side lane, and each lane is set up by its own 16-bit field. The field either routes a serial port's word-select edge to the lane, or names one of five divided sources and a divider index. The five sources are three external audio clocks and two baud-rate generator outputs. Each source arrives as a one-cycle tick in the system clock domain. A divided lane counts ticks of its source and raises a strobe on every N-th tick. N comes from a fixed nonlinear ladder: 2, 4, 6, 8, and then steps that alternate between x1.5 and x4/3.

Two channels share each 32-bit timing word, one for the input side and one for the output side. A divider-enable vector gates each divided source. The lane fields come from a configuration register block, which is not part of this design. This design does not pick the divider from a target rate, and it does not contain the rate-converter datapath.

Top module: `rate_strobe_sel`

## Requirements
- R1: Channel c reads its field from timing word c/2. An even channel uses bits [15:0] of that word and an odd channel uses bits [31:16]. Within the 16-bit field, bits [11:8] are the source select and bits [4:0] are the divider index. Bits [15:12] and [7:5] have no effect.
- R2: Select codes 0 to 4 pick divided sources from `src_tick` bits 0 to 4. These are audio clock A, audio clock B, audio clock C, generator A and generator B. Ticks of any other source do not advance the lane.
- R3: Divider indices 0, 1, 2 and 3 divide by 2, 4, 6 and 8.
- R4: For indices 4 to 28, the divide ratio alternates from 12: 12, 16, 24, 32, 48, 64, and so on. Index 28 divides by 49152.
- R5: Indices 29, 30 and 31 all divide by 98304.
- R6: A divided lane with source s runs only while `div_en` bit s+1 is 1. While that bit is 0 the lane gives no strobes and its count is held at zero.
- R7: Select code 6+w makes the lane's strobe follow word-select edge w. The strobe is registered and appears one clock after the edge.
- R8: When `pin_share` bit w is 1, select code 6+w is remapped as follows: ports 1, 2 and 9 take edge 0, port 4 takes edge 3, and port 8 takes edge 7. Any other port takes its own edge. When the bit is 0, no remap is applied.
- R9: A divided strobe is a one-clock pulse, registered one clock after the clock edge that counts the N-th tick. Consecutive strobes are exactly N ticks apart.
- R10: When a lane's select or index changes, the count restarts from zero on the first clock edge that sees the new value. A tick in that same cycle is not counted.
- R11: Select code 5, and any select code with no matching port, give no strobes.
- R12: The input-side and output-side fields of the same channel are independent. Each field drives only its own strobe.
- R13: While reset is asserted, every strobe is low and every count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | NSRC | One-cycle ticks of the divided sources (A, B, C clocks, then generators A, B) |
| ws_edge | input | NPORT | One-cycle word-select edge pulses per serial port |
| pin_share | input | NPORT | Per-port pin-sharing flag that enables the word-select remap |
| div_en | input | NSRC+1 | Divider enables; bit s+1 gates source s, bit 0 unused |
| in_timing_cfg | input | ((NCH+1)/2)*32 | Input-side timing words, two channels per word |
| out_timing_cfg | input | ((NCH+1)/2)*32 | Output-side timing words, two channels per word |
| in_strobe | output | NCH | Input-side timing strobe per channel |
| out_strobe | output | NCH | Output-side timing strobe per channel |

## Verification
Every strobe comes out of a register. A word-select lane shows its strobe one clock after the edge. A divided lane shows its strobe one clock after the edge that counts the N-th tick. After a field change, the restart edge adds one clock before counting resumes. The bench drives inputs and samples outputs on the falling edge. With a source that ticks every cycle, a divided lane's strobes therefore fall exactly N samples apart, and a strobe after a field change falls exactly N+1 samples after the change. The bench checks those exact sample positions. It also checks the sample just after each word-select strobe, to confirm that the pulse has already dropped.

// File: rtl/rss_pkg.sv
package rss_pkg;

  localparam int FIELD_W = 16;
  localparam int SEL_W   = 4;
  localparam int IDX_W   = 5;
  localparam int RATIO_W = 17;
  localparam int WS_BASE = 6;
  localparam int SEL_LSB = 8;
  localparam int IDX_LSB = 0;
  localparam logic [RATIO_W-1:0] RATIO_TOP = 17'd98304;

  // Divide ratio for a ladder index: 2,4,6,8 then 12,16,24,32,... ; 29 and above saturate.
  function automatic logic [RATIO_W-1:0] ladder_ratio(input logic [IDX_W-1:0] idx);
    logic [IDX_W-1:0] k;
    if (idx < IDX_W'(4)) return RATIO_W'({idx, 1'b0}) + RATIO_W'(2);
    if (idx >= IDX_W'(29)) return RATIO_TOP;
    k = idx - IDX_W'(4);
    return (k[0] ? RATIO_W'(16) : RATIO_W'(12)) << k[IDX_W-1:1];
  endfunction

  // Word-select port remap applied when the selected port shares its pins.
  function automatic logic [SEL_W-1:0] ws_remap(input logic [SEL_W-1:0] port,
                                                input logic share);
    if (!share) return port;
    case (port)
      SEL_W'(1), SEL_W'(2), SEL_W'(9): return SEL_W'(0);
      SEL_W'(4):                       return SEL_W'(3);
      SEL_W'(8):                       return SEL_W'(7);
      default:                         return port;
    endcase
  endfunction

endpackage

// File: rtl/rss_ladder_div.sv
module rss_ladder_div #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] ratio,
  output logic             hit
);

  logic [CNT_W-1:0] cnt_q;

  assign hit = run && tick && !restart && (cnt_q == ratio - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!run || restart) cnt_q <= '0;
    else if (hit)             cnt_q <= '0;
    else if (tick)            cnt_q <= cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/rss_chan.sv
module rss_chan
  import rss_pkg::*;
#(
  parameter int NSRC  = 5,
  parameter int NPORT = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] field,
  input  logic [NSRC-1:0]    src_tick,
  input  logic [NPORT-1:0]   ws_edge,
  input  logic [NPORT-1:0]   pin_share,
  input  logic [NSRC:0]      div_en,
  output logic               strobe,
  output logic               is_div,
  output logic               gate_on,
  output logic               is_ws,
  output logic               ws_pick,
  output logic               is_none,
  output logic               div_pulse
);

  localparam int SIW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int EIW = $clog2(NSRC + 1);
  localparam int PIW = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam int KEY_W = SEL_W + IDX_W;

  logic [SEL_W-1:0] sel;
  logic [IDX_W-1:0] idx;
  logic [SEL_W-1:0] port_raw;
  logic [SEL_W-1:0] port_eff;
  logic [EIW-1:0]   en_pos;
  logic             tick_sel;
  logic [KEY_W-1:0] key_q;
  logic             restart;
  logic             strobe_q;
  logic             rsv_unused;

  assign sel        = field[SEL_LSB +: SEL_W];
  assign idx        = field[IDX_LSB +: IDX_W];
  assign rsv_unused = ^{field[FIELD_W-1:SEL_LSB+SEL_W], field[SEL_LSB-1:IDX_LSB+IDX_W]};

  always_comb begin
    is_div   = int'(sel) < NSRC;
    port_raw = sel - SEL_W'(WS_BASE);
    is_ws    = (int'(sel) >= WS_BASE) && (int'(port_raw) < NPORT);
    is_none  = !is_div && !is_ws;
    port_eff = ws_remap(port_raw, is_ws && pin_share[port_raw[PIW-1:0]]);
    ws_pick  = is_ws && ws_edge[port_eff[PIW-1:0]];
    en_pos   = EIW'(sel) + EIW'(1);
    gate_on  = is_div && div_en[en_pos];
    tick_sel = is_div && src_tick[sel[SIW-1:0]];
  end

  assign restart = {sel, idx} != key_q;

  rss_ladder_div #(.CNT_W(RATIO_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (gate_on),
    .restart (restart),
    .tick    (tick_sel),
    .ratio   (ladder_ratio(idx)),
    .hit     (div_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      key_q    <= {sel, idx};
      strobe_q <= is_ws ? ws_pick : div_pulse;
    end
  end

  assign strobe = strobe_q;

endmodule

// File: rtl/rate_strobe_sel.sv
module rate_strobe_sel
  import rss_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int NSRC  = 5,
  parameter int NPORT = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NSRC-1:0]             src_tick,
  input  logic [NPORT-1:0]            ws_edge,
  input  logic [NPORT-1:0]            pin_share,
  input  logic [NSRC:0]               div_en,
  input  logic [((NCH+1)/2)*32-1:0]   in_timing_cfg,
  input  logic [((NCH+1)/2)*32-1:0]   out_timing_cfg,
  output logic [NCH-1:0]              in_strobe,
  output logic [NCH-1:0]              out_strobe
);

  localparam int LANES = 2 * NCH;
  localparam int WORD_W = 2 * FIELD_W;

  logic [LANES-1:0] lane_strobe;
  logic [LANES-1:0] lane_is_div;
  logic [LANES-1:0] lane_gate_on;
  logic [LANES-1:0] lane_is_ws;
  logic [LANES-1:0] lane_ws_pick;
  logic [LANES-1:0] lane_is_none;
  logic [LANES-1:0] lane_div_pulse;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int CH   = g % NCH;
    localparam int BASE = (CH / 2) * WORD_W + (CH % 2) * FIELD_W;
    logic [FIELD_W-1:0] fld;

    if (g < NCH) begin : g_in
      assign fld = in_timing_cfg[BASE +: FIELD_W];
    end else begin : g_out
      assign fld = out_timing_cfg[BASE +: FIELD_W];
    end

    rss_chan #(.NSRC(NSRC), .NPORT(NPORT)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .field     (fld),
      .src_tick  (src_tick),
      .ws_edge   (ws_edge),
      .pin_share (pin_share),
      .div_en    (div_en),
      .strobe    (lane_strobe[g]),
      .is_div    (lane_is_div[g]),
      .gate_on   (lane_gate_on[g]),
      .is_ws     (lane_is_ws[g]),
      .ws_pick   (lane_ws_pick[g]),
      .is_none   (lane_is_none[g]),
      .div_pulse (lane_div_pulse[g])
    );
  end

  assign in_strobe  = lane_strobe[NCH-1:0];
  assign out_strobe = lane_strobe[LANES-1:NCH];

endmodule

// File: rtl/rss_checker.sv
module rss_checker #(
  parameter int LANES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LANES-1:0] lane_strobe,
  input logic [LANES-1:0] lane_is_div,
  input logic [LANES-1:0] lane_gate_on,
  input logic [LANES-1:0] lane_is_ws,
  input logic [LANES-1:0] lane_ws_pick,
  input logic [LANES-1:0] lane_is_none,
  input logic [LANES-1:0] lane_div_pulse
);

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    // R9: a divider terminal count never repeats on the next cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      lane_div_pulse[l] |=> !lane_div_pulse[l]);

    // R9: a divided lane's strobe is the terminal count one clock later
    a_r9_strobe_delay: assert property (@(posedge clk) disable iff (!rst_n)
      lane_is_div[l] |=> (lane_strobe[l] == $past(lane_div_pulse[l])));

    // R6: a gated-off source gives no strobe
    a_r6_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_is_div[l] && !lane_gate_on[l]) |=> !lane_strobe[l]);

    // R7: word-select lane follows its chosen edge one clock later
    a_r7_ws_follow: assert property (@(posedge clk) disable iff (!rst_n)
      lane_is_ws[l] |=> (lane_strobe[l] == $past(lane_ws_pick[l])));

    // R11: reserved select yields no strobe
    a_r11_no_source: assert property (@(posedge clk) disable iff (!rst_n)
      lane_is_none[l] |=> !lane_strobe[l]);
  end

endmodule

bind rate_strobe_sel rss_checker #(.LANES(2 * NCH)) u_rss_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .lane_strobe    (lane_strobe),
  .lane_is_div    (lane_is_div),
  .lane_gate_on   (lane_gate_on),
  .lane_is_ws     (lane_is_ws),
  .lane_ws_pick   (lane_ws_pick),
  .lane_is_none   (lane_is_none),
  .lane_div_pulse (lane_div_pulse)
);

// File: tb/rate_strobe_sel_test.sv
`timescale 1ns/1ps
module rate_strobe_sel_test;

  localparam int NCH = 4;
  localparam int NSRC = 5;
  localparam int NPORT = 10;
  localparam int CFG_W = ((NCH + 1) / 2) * 32;
  localparam int NVEC = 14;
  // columns: side (0 in / 1 out), channel, source select, ladder index, expected ratio
  localparam int VEC [NVEC][5] = '{
    '{0, 0, 0,  0,   2}, '{1, 0, 1,  1,   4}, '{0, 1, 2,  2,   6},
    '{1, 1, 3,  3,   8}, '{0, 2, 4,  4,  12}, '{1, 2, 0,  5,  16},
    '{0, 3, 1,  6,  24}, '{1, 3, 2,  7,  32}, '{0, 0, 3,  8,  48},
    '{1, 0, 4,  9,  64}, '{0, 1, 0, 10,  96}, '{1, 1, 1, 11, 128},
    '{0, 2, 2, 12, 192}, '{1, 2, 3, 13, 256}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NSRC-1:0]  src_tick = '0;
  logic [NPORT-1:0] ws_edge = '0;
  logic [NPORT-1:0] pin_share = '0;
  logic [NSRC:0]    div_en = '0;
  logic [CFG_W-1:0] in_cfg = '0;
  logic [CFG_W-1:0] out_cfg = '0;
  logic [NCH-1:0]   in_strobe;
  logic [NCH-1:0]   out_strobe;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  rate_strobe_sel #(.NCH(NCH), .NSRC(NSRC), .NPORT(NPORT)) uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .src_tick       (src_tick),
    .ws_edge        (ws_edge),
    .pin_share      (pin_share),
    .div_en         (div_en),
    .in_timing_cfg  (in_cfg),
    .out_timing_cfg (out_cfg),
    .in_strobe      (in_strobe),
    .out_strobe     (out_strobe)
  );

  function automatic logic [15:0] mkf(input int sel, input int idx);
    return {4'h0, sel[3:0], 3'b000, idx[4:0]};
  endfunction

  function automatic logic strobe_of(input int d, input int ch);
    return d != 0 ? out_strobe[ch] : in_strobe[ch];
  endfunction

  task automatic set_field(input int d, input int ch, input logic [15:0] f);
    if (d != 0) out_cfg[(ch / 2) * 32 + (ch % 2) * 16 +: 16] = f;
    else        in_cfg[(ch / 2) * 32 + (ch % 2) * 16 +: 16] = f;
  endtask

  task automatic clear_fields();
    for (int c = 0; c < NCH; c++) begin
      set_field(0, c, mkf(5, 0));
      set_field(1, c, mkf(5, 0));
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic measure(input int d, input int ch, input int limit, output int per);
    int last;
    last = -1;
    per = -1;
    for (int n = 0; n < limit; n++) begin
      @(negedge clk);
      if (strobe_of(d, ch)) begin
        if (last >= 0) begin
          per = n - last;
          return;
        end
        last = n;
      end
    end
  endtask

  task automatic quiet(input int d, input int ch, input int cycles, input string req);
    int seen;
    seen = 0;
    for (int n = 0; n < cycles; n++) begin
      @(negedge clk);
      if (strobe_of(d, ch)) seen++;
    end
    check(seen == 0, req, "strobes on silent lane", seen, 0);
  endtask

  task automatic ws_probe(input int d, input int ch, input int port, input bit exp,
                          input string req);
    logic s1, s2;
    @(negedge clk);
    ws_edge = '0;
    ws_edge[port] = 1'b1;
    @(negedge clk);
    s1 = strobe_of(d, ch);
    ws_edge = '0;
    @(negedge clk);
    s2 = strobe_of(d, ch);
    check(s1 == exp, req, $sformatf("strobe after edge %0d", port), s1, exp);
    check(s2 == 1'b0, req, "strobe one clock later", s2, 0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin : main
    int per;
    int first [NCH];
    int second0;

    // R13: reset state
    repeat (3) @(negedge clk);
    check(in_strobe == '0 && out_strobe == '0, "R13", "strobes in reset",
          {out_strobe, in_strobe}, 0);
    rst_n = 1'b1;

    // R6: all enables low after reset, every lane on a divided source
    src_tick = '1;
    quiet(0, 0, 20, "R6");

    // Ladder table walk (R2, R3, R4, R9, R12 across sides and channels)
    div_en = 6'b111110;
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      clear_fields();
      set_field(VEC[i][0], VEC[i][1], mkf(VEC[i][2], VEC[i][3]));
      measure(VEC[i][0], VEC[i][1], 2 * VEC[i][4] + 10, per);
      check(per == VEC[i][4], VEC[i][3] < 4 ? "R3" : "R4",
            $sformatf("period idx %0d", VEC[i][3]), per, VEC[i][4]);
    end

    // R1: odd channel in upper half, reserved bits ignored
    @(negedge clk);
    clear_fields();
    set_field(0, 1, {4'hA, 4'd2, 3'b101, 5'd0});
    measure(0, 1, 20, per);
    check(per == 2, "R1", "odd channel upper half period", per, 2);

    // R12 and R11: same channel, input divided, output reserved select
    @(negedge clk);
    clear_fields();
    set_field(0, 0, mkf(0, 0));
    measure(0, 0, 20, per);
    check(per == 2, "R12", "input lane period", per, 2);
    quiet(1, 0, 20, "R11");

    // R2: source codes map to src_tick bits
    for (int s = 0; s < NSRC; s++) begin
      @(negedge clk);
      clear_fields();
      set_field(0, 2, mkf(s, 0));
      src_tick = '0;
      src_tick[(s + 1) % NSRC] = 1'b1;
      quiet(0, 2, 20, "R2");
      src_tick = '0;
      src_tick[s] = 1'b1;
      measure(0, 2, 20, per);
      check(per == 2, "R2", $sformatf("period on source %0d", s), per, 2);
    end
    src_tick = '1;

    // R6: gating by div_en bit sel+1
    @(negedge clk);
    clear_fields();
    set_field(0, 3, mkf(3, 1));
    div_en = 6'b101110;
    quiet(0, 3, 20, "R6");
    div_en = 6'b111110;
    measure(0, 3, 30, per);
    check(per == 4, "R6", "period after enable", per, 4);

    // R10: field change restarts the count
    @(negedge clk);
    clear_fields();
    set_field(0, 0, mkf(0, 3));
    per = 0;
    for (int n = 0; n < 40 && per == 0; n++) begin
      @(negedge clk);
      if (in_strobe[0]) per = 1;
    end
    repeat (4) @(negedge clk);
    set_field(0, 0, mkf(1, 3));
    per = 0;
    for (int n = 1; n <= 8; n++) begin
      @(negedge clk);
      if (in_strobe[0]) per++;
    end
    check(per == 0, "R10", "strobes before restart completes", per, 0);
    @(negedge clk);
    check(in_strobe[0] == 1'b1, "R10", "strobe at ninth sample", in_strobe[0], 1);

    // R7: word-select routing
    @(negedge clk);
    clear_fields();
    set_field(1, 1, mkf(6 + 3, 0));
    ws_probe(1, 1, 3, 1'b1, "R7");
    ws_probe(1, 1, 4, 1'b0, "R7");

    // R8: pin-sharing remap
    pin_share = '0;
    pin_share[8] = 1'b1;
    pin_share[2] = 1'b1;
    pin_share[5] = 1'b1;
    set_field(1, 1, mkf(6 + 8, 0));
    ws_probe(1, 1, 7, 1'b1, "R8");
    ws_probe(1, 1, 8, 1'b0, "R8");
    set_field(1, 1, mkf(6 + 2, 0));
    ws_probe(1, 1, 0, 1'b1, "R8");
    set_field(1, 1, mkf(6 + 5, 0));
    ws_probe(1, 1, 5, 1'b1, "R8");
    pin_share = '0;
    set_field(1, 1, mkf(6 + 8, 0));
    ws_probe(1, 1, 8, 1'b1, "R8");

    // R4, R5: top of the ladder, run in parallel
    @(negedge clk);
    clear_fields();
    set_field(0, 0, mkf(0, 28));
    set_field(0, 1, mkf(0, 29));
    set_field(0, 2, mkf(0, 30));
    set_field(0, 3, mkf(0, 31));
    for (int c = 0; c < NCH; c++) first[c] = -1;
    second0 = -1;
    for (int n = 1; n <= 98310; n++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        if (in_strobe[c]) begin
          if (first[c] < 0) first[c] = n;
          else if (c == 0 && second0 < 0) second0 = n;
        end
      end
    end
    check(first[0] == 49153, "R4", "index 28 first strobe", first[0], 49153);
    check(second0 == 98305, "R4", "index 28 second strobe", second0, 98305);
    check(first[1] == 98305, "R5", "index 29 first strobe", first[1], 98305);
    check(first[2] == 98305, "R5", "index 30 first strobe", first[2], 98305);
    check(first[3] == 98305, "R5", "index 31 first strobe", first[3], 98305);

    summary();
    $finish;
  end

endmodule